// File: doc/BRIEF.md
# Adaptive Source Route Field Decoder

This block sits at one input port of an eight-port switch. It reads the route header of each arriving packet. From that header it works out the set of output ports the packet may take at this hop. The header opens with a count of adaptive route fields that are still pending, followed by route nibbles with the current field first.

When the count is non-zero, the current nibble is a permission mask. Each bit allows one port on the side of the switch opposite the entry port, so a packet on its upward path always crosses to the other side. An all-ones nibble allows all four ports on that side, and a single set bit pins the hop to one port. When the count is zero, the nibble is a fixed hop and its low three bits name one output port.

The block also produces the header for the next hop. In that header the used field is removed, and the count is lowered by one if the used field was adaptive. All results are registered and appear one cycle after the header strobe. Choosing among the candidate ports and moving the payload are left to other logic.

Top module: `ars_route_decode`

## Requirements
- R1: While reset is high and in the cycle after it, `res_valid`, `cand_mask`, `adaptive`, `hdr_err` and `hdr_out` are all zero.
- R2: `res_valid` is high exactly in the cycle after a cycle in which `hdr_valid` was high, and low otherwise.
- R3: The count is `hdr_in[31:28]` and the current nibble is `hdr_in[27:24]`. With a non-zero count and a non-zero nibble, `adaptive` is 1 and `hdr_err` is 0. Nibble bit i sets `cand_mask` bit 4+i when the entry port is 0 to 3, and bit i when the entry port is 4 to 7. No port on the entry side is ever a candidate.
- R4: After an adaptive hop without error, `hdr_out` is {count-1, `hdr_in[23:0]`, 4'b0000}.
- R5: With a count of zero, `adaptive` is 0 and `cand_mask` is one-hot at the port given by nibble bits [2:0], whatever the entry port. Nibble bit 3 is ignored.
- R6: After a fixed hop, `hdr_out` is {4'b0000, `hdr_in[23:0]`, 4'b0000}.
- R7: A non-zero count with a zero nibble sets `hdr_err` and `adaptive`, clears `cand_mask`, and returns `hdr_in` unchanged on `hdr_out`.
- R8: With a count of 15, the rewritten count is 14. A header fed back through the decoder hop by hop performs its adaptive hops first and its fixed hops after.
- R9: In cycles following a cycle without a strobe, `cand_mask`, `adaptive`, `hdr_err` and `hdr_out` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header strobe, one cycle per header |
| entry_port | input | 3 | Port number the packet arrived on |
| hdr_in | input | 32 | Route header word |
| res_valid | output | 1 | Decode result valid |
| cand_mask | output | 8 | Candidate output ports, one bit per port |
| adaptive | output | 1 | Hop used an adaptive field |
| hdr_err | output | 1 | Adaptive field allowed no port |
| hdr_out | output | 32 | Header for the next hop |

## Verification
The assertions assume that `entry_port` and `hdr_in` are settled in every cycle in which `hdr_valid` is high. They also assume that no strobe arrives while reset is held, because their `$past` terms read those inputs in the strobe cycle. The stimulus drives inputs only on falling edges and releases reset before the first strobe. It covers both entry sides, all eight fixed ports with nibble bit 3 set and clear, zero masks, the maximum count, back-to-back strobes, idle gaps, and a header chained through several hops.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic [1:0] {
    HOP_FIXED = 2'd0,
    HOP_ADAPT = 2'd1,
    HOP_BAD   = 2'd2
  } hop_kind_e;
endpackage

// File: rtl/ars_field_split.sv
module ars_field_split
  import ars_pkg::*;
#(
  parameter int HDR_W = 32,
  parameter int CNT_W = 4,
  parameter int FLD_W = 4
) (
  input  logic [HDR_W-1:0] hdr,
  output logic [FLD_W-1:0] nib,
  output hop_kind_e        kind,
  output logic [HDR_W-1:0] hdr_next
);
  localparam int REST_W = HDR_W - CNT_W - FLD_W;

  logic [CNT_W-1:0] cnt;
  logic [REST_W-1:0] rest;

  assign cnt  = hdr[HDR_W-1 -: CNT_W];
  assign nib  = hdr[HDR_W-CNT_W-1 -: FLD_W];
  assign rest = hdr[REST_W-1:0];

  always_comb begin
    if (cnt == '0) begin
      kind     = HOP_FIXED;
      hdr_next = {cnt, rest, {FLD_W{1'b0}}};
    end else if (nib == '0) begin
      kind     = HOP_BAD;
      hdr_next = hdr;
    end else begin
      kind     = HOP_ADAPT;
      hdr_next = {cnt - CNT_W'(1), rest, {FLD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/ars_mask_gen.sv
module ars_mask_gen
  import ars_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int FLD_W  = 4
) (
  input  hop_kind_e               kind,
  input  logic [FLD_W-1:0]        nib,
  input  logic [PORT_W-1:0]       port,
  output logic [(1<<PORT_W)-1:0]  mask
);
  localparam int NPORT = 1 << PORT_W;
  localparam int SIDE  = NPORT / 2;

  logic in_upper;
  assign in_upper = port[PORT_W-1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic UPPER = (p >= SIDE);
    logic adapt_bit, fixed_bit;
    assign adapt_bit = (UPPER != in_upper) && nib[p % SIDE];
    assign fixed_bit = (nib[PORT_W-1:0] == PORT_W'(p));
    always_comb begin
      case (kind)
        HOP_ADAPT: mask[p] = adapt_bit;
        HOP_FIXED: mask[p] = fixed_bit;
        default:   mask[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ars_route_decode.sv
module ars_route_decode
  import ars_pkg::*;
#(
  parameter int HDR_W  = 32,
  parameter int CNT_W  = 4,
  parameter int PORT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hdr_valid,
  input  logic [PORT_W-1:0]          entry_port,
  input  logic [HDR_W-1:0]           hdr_in,
  output logic                       res_valid,
  output logic [(1<<PORT_W)-1:0]     cand_mask,
  output logic                       adaptive,
  output logic                       hdr_err,
  output logic [HDR_W-1:0]           hdr_out
);
  localparam int NPORT = 1 << PORT_W;
  localparam int FLD_W = NPORT / 2;

  logic [FLD_W-1:0] nib;
  hop_kind_e        kind;
  logic [HDR_W-1:0] hdr_next;
  logic [NPORT-1:0] mask_c;

  ars_field_split #(.HDR_W(HDR_W), .CNT_W(CNT_W), .FLD_W(FLD_W)) u_split (
    .hdr(hdr_in), .nib(nib), .kind(kind), .hdr_next(hdr_next)
  );

  ars_mask_gen #(.PORT_W(PORT_W), .FLD_W(FLD_W)) u_mask (
    .kind(kind), .nib(nib), .port(entry_port), .mask(mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      cand_mask <= '0;
      adaptive  <= 1'b0;
      hdr_err   <= 1'b0;
      hdr_out   <= '0;
    end else begin
      res_valid <= hdr_valid;
      if (hdr_valid) begin
        cand_mask <= mask_c;
        adaptive  <= (kind != HOP_FIXED);
        hdr_err   <= (kind == HOP_BAD);
        hdr_out   <= hdr_next;
      end
    end
  end

  a_r2_strobe_on: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> res_valid);
  a_r2_strobe_off: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !res_valid);
  a_r3_far_side: assert property (@(posedge clk) disable iff (rst)
    (res_valid && adaptive) |->
      ($past(entry_port[PORT_W-1]) ? (cand_mask[NPORT-1:FLD_W] == '0)
                                   : (cand_mask[FLD_W-1:0] == '0)));
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (res_valid && adaptive && !hdr_err) |->
      (hdr_out[HDR_W-1 -: CNT_W] == $past(hdr_in[HDR_W-1 -: CNT_W]) - CNT_W'(1)));
  a_r5_one_port: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !adaptive) |-> ($countones(cand_mask) == 1));
  a_r7_no_cand: assert property (@(posedge clk) disable iff (rst)
    (res_valid && hdr_err) |-> (cand_mask == '0 && adaptive));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(cand_mask) && $stable(hdr_out)));
endmodule

// File: tb/ars_route_decode_test.sv
module ars_route_decode_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_valid = 1'b0;
  logic [2:0]  entry_port = '0;
  logic [31:0] hdr_in = '0;
  logic        res_valid, adaptive, hdr_err;
  logic [7:0]  cand_mask;
  logic [31:0] hdr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic        e_v = 0, e_ad = 0, e_er = 0;
  logic [7:0]  e_m = 0;
  logic [31:0] e_h = 0;
  string       tag = "R1";
  string       cur_tag = "R1";

  always #(CLK_NS/2) clk = ~clk;

  ars_route_decode uut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .entry_port(entry_port),
    .hdr_in(hdr_in), .res_valid(res_valid), .cand_mask(cand_mask),
    .adaptive(adaptive), .hdr_err(hdr_err), .hdr_out(hdr_out)
  );

  // behavioural reference, one cycle of latency
  always @(posedge clk) begin
    int cnt, nib;
    if (rst) begin
      e_v <= 0; e_ad <= 0; e_er <= 0; e_m <= 0; e_h <= 0; tag <= "R1";
    end else begin
      e_v <= hdr_valid;
      if (!hdr_valid) tag <= "R9";
      else begin
        tag <= cur_tag;
        cnt = int'(hdr_in[31:28]);
        nib = int'(hdr_in[27:24]);
        if (cnt == 0) begin
          e_ad <= 0; e_er <= 0;
          e_m  <= 8'(1 << (nib % 8));
          e_h  <= {4'h0, hdr_in[23:0], 4'h0};
        end else if (nib == 0) begin
          e_ad <= 1; e_er <= 1; e_m <= 0; e_h <= hdr_in;
        end else begin
          e_ad <= 1; e_er <= 0;
          e_m  <= (entry_port < 4) ? 8'(nib << 4) : 8'(nib);
          e_h  <= {4'(cnt - 1), hdr_in[23:0], 4'h0};
        end
      end
    end
  end

  task automatic check(string t, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done)
      check(rst ? "R1" : tag,
            {5'b0, res_valid, adaptive, hdr_err, cand_mask, hdr_out},
            {5'b0, e_v, e_ad, e_er, e_m, e_h});
  end

  task automatic drive(string t, logic v, logic [2:0] p, logic [31:0] h);
    @(negedge clk);
    cur_tag = t; hdr_valid = v; entry_port = p; hdr_in = h;
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] h;
    repeat (3) @(negedge clk);
    // R1: outputs zero after reset
    check("R1", {res_valid, adaptive, hdr_err, cand_mask, hdr_out}, '0);
    @(negedge clk); rst = 0;
    drive("R3", 1, 3'd1, 32'h3F12_3456);  // all four upper ports
    drive("R3", 1, 3'd6, 32'h2A00_0001);  // upper entry, lower ports 1,3
    drive("R4", 1, 3'd0, 32'h1412_3456);  // single bit
    drive("R7", 1, 3'd5, 32'h40AB_CDEF);  // zero mask
    drive("R9", 0, 3'd2, 32'hFFFF_FFFF);
    drive("R9", 0, 3'd2, 32'h1111_1111);
    for (int i = 0; i < 16; i++)          // fixed hops, bit 3 toggled
      drive(i < 8 ? "R5" : "R6", 1, 3'(i * 3), {4'h0, 4'(i), 24'h9A_BC_DE});
    drive("R8", 1, 3'd4, 32'hF912_3456);  // max count
    drive("R7", 1, 3'd0, 32'h1000_0000);
    drive("R9", 0, 3'd0, 32'h0);
    // R8: chain a header through five hops
    h = 32'h2C56_3700;
    for (int k = 0; k < 5; k++) begin
      drive("R8", 1, 3'(k * 5), h);
      @(posedge clk); #1;
      h = hdr_out;
    end
    drive("R9", 0, 3'd0, 32'h0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule